// File: doc/BRIEF.md
# Packet Router Control FSM

This block sequences the transfer of one byte-wide packet from the single ingress port of a one-to-three router into the output queue chosen for it. A packet is made of a header byte, some payload bytes and a closing parity byte. The controller watches a small set of status flags: the source's packet-valid line, the empty and full flags of the chosen queue, a parity-done flag and a low-packet-valid flag. It produces the write strobes and the back-pressure signal that the surrounding datapath uses.

Before it commits the header, the controller waits until the chosen queue has drained. It then writes the header, streams the payload, and parks in a stall state whenever the queue fills. On recovery it resumes at the right phase, writes the parity byte and runs a parity check before it accepts the next header. The address decode, the queues, the parity arithmetic and the output synchronizer sit outside this block. The bench drives all of their flags.

Top module: `pkt_route_ctrl`

States: DECODE (waiting for a header), WAIT_EMPTY (queue not yet drained), FIRST (header write), DATA (payload streaming), PARITY (parity byte write), FULL (stalled on a full queue), AFTER_FULL (recovery after a stall), CHECK (parity check).

## Requirements
- R1: The controller has exactly eight states. `state_oh` shows the current state one-hot, with exactly one bit set: bit0 DECODE, bit1 WAIT_EMPTY, bit2 FIRST, bit3 DATA, bit4 PARITY, bit5 FULL, bit6 AFTER_FULL, bit7 CHECK.
- R2: A synchronous active-low reset (`rst_n` = 0 at a clock edge) puts the controller in DECODE from any state.
- R3: In DECODE with `pkt_valid` = 1, the next state is FIRST when `fifo_empty` = 1 and WAIT_EMPTY when `fifo_empty` = 0. With `pkt_valid` = 0 the controller stays in DECODE.
- R4: WAIT_EMPTY holds while `fifo_empty` = 0 and moves to FIRST once `fifo_empty` = 1.
- R5: FIRST always moves to DATA on the next edge, whatever the flags are.
- R6: In DATA, `fifo_full` = 1 leads to FULL. Otherwise `pkt_valid` = 0 leads to PARITY. Otherwise the controller stays in DATA.
- R7: PARITY moves to FULL when `fifo_full` = 1 and to CHECK when `fifo_full` = 0.
- R8: FULL holds while `fifo_full` = 1 and moves to AFTER_FULL when it clears.
- R9: From AFTER_FULL, `parity_done` = 1 returns to DECODE. Otherwise `low_pkt_valid` = 1 leads to PARITY and `low_pkt_valid` = 0 leads to DATA.
- R10: CHECK moves to FULL when `fifo_full` = 1 and back to DECODE when `fifo_full` = 0.
- R11: Each strobe is high exactly in its state: `load_hdr` in FIRST, `load_data` in DATA, `load_laf` in AFTER_FULL, `load_parity` in PARITY, `check_parity` in CHECK.
- R12: `busy` is low in DECODE and DATA and high in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_valid | input | 1 | Source is presenting packet bytes |
| fifo_empty | input | 1 | Chosen output queue is empty |
| fifo_full | input | 1 | Chosen output queue is full |
| parity_done | input | 1 | Parity byte already taken |
| low_pkt_valid | input | 1 | Packet ended while the queue was stalled |
| state_oh | output | 8 | One-hot current state |
| load_hdr | output | 1 | Write the header byte |
| load_data | output | 1 | Write a payload byte |
| load_laf | output | 1 | Write the byte held across a stall |
| load_parity | output | 1 | Write the parity byte |
| check_parity | output | 1 | Compare computed and received parity |
| busy | output | 1 | Stall request to the source |

## Verification
The stimulus walks the controller through several packet shapes. A header that finds its queue empty separates the direct path from one that must first wait for a drain. A payload that ends without a stall is tried against payloads that stall during data, during the parity write and during the check, and each stall path shows whether recovery resumes in the proper phase. The three exits from AFTER_FULL are each taken, so the priority of `parity_done` over `low_pkt_valid` shows up in the results. A reset in the middle of a packet, and flags that FIRST must ignore, confirm that those inputs do not disturb the sequencing.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int unsigned PRC_NUM_STATES = 8;
    localparam int unsigned PRC_STATE_W    = $clog2(PRC_NUM_STATES);

    typedef enum logic [PRC_STATE_W-1:0] {
        ST_DECODE      = 3'd0,
        ST_WAIT_EMPTY  = 3'd1,
        ST_FIRST       = 3'd2,
        ST_DATA        = 3'd3,
        ST_PARITY      = 3'd4,
        ST_FULL        = 3'd5,
        ST_AFTER_FULL  = 3'd6,
        ST_CHECK       = 3'd7
    } prc_state_e;

    typedef struct packed {
        logic pkt_valid;
        logic fifo_empty;
        logic fifo_full;
        logic parity_done;
        logic low_pkt_valid;
    } prc_flags_t;

endpackage

// File: rtl/prc_next_state.sv
module prc_next_state
    import prc_pkg::*;
(
    input  prc_state_e cur,
    input  prc_flags_t flags,
    output prc_state_e nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_DECODE: begin
                if (flags.pkt_valid)
                    nxt = flags.fifo_empty ? ST_FIRST : ST_WAIT_EMPTY;
            end
            ST_WAIT_EMPTY: begin
                if (flags.fifo_empty)
                    nxt = ST_FIRST;
            end
            ST_FIRST: begin
                nxt = ST_DATA;
            end
            ST_DATA: begin
                if (flags.fifo_full)
                    nxt = ST_FULL;
                else if (!flags.pkt_valid)
                    nxt = ST_PARITY;
            end
            ST_PARITY: begin
                nxt = flags.fifo_full ? ST_FULL : ST_CHECK;
            end
            ST_FULL: begin
                if (!flags.fifo_full)
                    nxt = ST_AFTER_FULL;
            end
            ST_AFTER_FULL: begin
                if (flags.parity_done)
                    nxt = ST_DECODE;
                else if (flags.low_pkt_valid)
                    nxt = ST_PARITY;
                else
                    nxt = ST_DATA;
            end
            ST_CHECK: begin
                nxt = flags.fifo_full ? ST_FULL : ST_DECODE;
            end
            default: nxt = ST_DECODE;
        endcase
    end

endmodule

// File: rtl/prc_state_reg.sv
module prc_state_reg
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  prc_state_e nxt,
    output prc_state_e cur
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= ST_DECODE;
        else
            cur <= nxt;
    end

endmodule

// File: rtl/prc_out_decode.sv
module prc_out_decode
    import prc_pkg::*;
#(
    parameter int unsigned NUM_STATES = PRC_NUM_STATES
) (
    input  prc_state_e            cur,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  load_hdr,
    output logic                  load_data,
    output logic                  load_laf,
    output logic                  load_parity,
    output logic                  check_parity,
    output logic                  busy
);

    for (genvar gi = 0; gi < NUM_STATES; gi++) begin : g_oh
        assign state_oh[gi] = (cur == prc_state_e'(gi));
    end

    always_comb begin
        load_hdr     = 1'b0;
        load_data    = 1'b0;
        load_laf     = 1'b0;
        load_parity  = 1'b0;
        check_parity = 1'b0;
        busy         = 1'b1;
        unique case (cur)
            ST_DECODE:     busy = 1'b0;
            ST_WAIT_EMPTY: ;
            ST_FIRST:      load_hdr = 1'b1;
            ST_DATA: begin
                load_data = 1'b1;
                busy      = 1'b0;
            end
            ST_PARITY:     load_parity = 1'b1;
            ST_FULL:       ;
            ST_AFTER_FULL: load_laf = 1'b1;
            ST_CHECK:      check_parity = 1'b1;
            default:       busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/pkt_route_ctrl.sv
module pkt_route_ctrl
    import prc_pkg::*;
#(
    parameter int unsigned NUM_STATES = PRC_NUM_STATES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_valid,
    input  logic                  fifo_empty,
    input  logic                  fifo_full,
    input  logic                  parity_done,
    input  logic                  low_pkt_valid,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  load_hdr,
    output logic                  load_data,
    output logic                  load_laf,
    output logic                  load_parity,
    output logic                  check_parity,
    output logic                  busy
);

    prc_state_e cur_q;
    prc_state_e nxt_d;
    prc_flags_t flags;

    assign flags = '{pkt_valid:     pkt_valid,
                     fifo_empty:    fifo_empty,
                     fifo_full:     fifo_full,
                     parity_done:   parity_done,
                     low_pkt_valid: low_pkt_valid};

    prc_next_state u_next (
        .cur   (cur_q),
        .flags (flags),
        .nxt   (nxt_d)
    );

    prc_state_reg u_sreg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_d),
        .cur   (cur_q)
    );

    prc_out_decode #(.NUM_STATES(NUM_STATES)) u_odec (
        .cur          (cur_q),
        .state_oh     (state_oh),
        .load_hdr     (load_hdr),
        .load_data    (load_data),
        .load_laf     (load_laf),
        .load_parity  (load_parity),
        .check_parity (check_parity),
        .busy         (busy)
    );

endmodule

// File: rtl/prc_checker.sv
module prc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pkt_valid,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic [7:0] state_oh,
    input logic       busy
);

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1); // R1

    AST_DECODE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && pkt_valid && fifo_empty) |=> state_oh[2]); // R3

    AST_FIRST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[2] |=> state_oh[3]); // R5

    AST_DATA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] && fifo_full) |=> state_oh[5]); // R6

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[5] && fifo_full) |=> state_oh[5]); // R8

    AST_BUSY_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !(state_oh[0] || state_oh[3])); // R12

endmodule

bind pkt_route_ctrl prc_checker u_prc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .state_oh   (state_oh),
    .busy       (busy)
);

// File: tb/tb_pkt_route_ctrl.sv
`timescale 1ns/1ps
module tb_pkt_route_ctrl;

    localparam logic [7:0] S_DEC  = 8'h01;
    localparam logic [7:0] S_WAIT = 8'h02;
    localparam logic [7:0] S_FRST = 8'h04;
    localparam logic [7:0] S_DATA = 8'h08;
    localparam logic [7:0] S_PAR  = 8'h10;
    localparam logic [7:0] S_FULL = 8'h20;
    localparam logic [7:0] S_LAF  = 8'h40;
    localparam logic [7:0] S_CHK  = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n, pkt_valid, fifo_empty, fifo_full, parity_done, low_pkt_valid;
    logic [7:0] state_oh;
    logic       load_hdr, load_data, load_laf, load_parity, check_parity, busy;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] exp_oh;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    pkt_route_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_valid     (pkt_valid),
        .fifo_empty    (fifo_empty),
        .fifo_full     (fifo_full),
        .parity_done   (parity_done),
        .low_pkt_valid (low_pkt_valid),
        .state_oh      (state_oh),
        .load_hdr      (load_hdr),
        .load_data     (load_data),
        .load_laf      (load_laf),
        .load_parity   (load_parity),
        .check_parity  (check_parity),
        .busy          (busy)
    );

    task automatic drive(input logic r, input logic pv, input logic em, input logic fu,
                         input logic pd, input logic lp, input logic [7:0] exp,
                         input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n         = r;
        pkt_valid     = pv;
        fifo_empty    = em;
        fifo_full     = fu;
        parity_done   = pd;
        low_pkt_valid = lp;
        it.exp_oh = exp;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each edge, compare against the oldest expectation
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [5:0] exp_out, act_out;
            it = sb_q.pop_front();
            checks++;
            if (state_oh !== it.exp_oh) begin
                failures++;
                $display("FAIL %s state_oh actual=%h expected=%h", it.tag, state_oh, it.exp_oh);
            end
            // R11 strobes and R12 busy, derived from the expected state
            exp_out = {it.exp_oh[2], it.exp_oh[3], it.exp_oh[6], it.exp_oh[4], it.exp_oh[7],
                       !(it.exp_oh[0] || it.exp_oh[3])};
            act_out = {load_hdr, load_data, load_laf, load_parity, check_parity, busy};
            checks++;
            if (act_out !== exp_out) begin
                failures++;
                $display("FAIL R11/R12 (%s) strobes actual=%b expected=%b", it.tag, act_out, exp_out);
            end
        end
    end

    initial begin
        rst_n = 1'b0; pkt_valid = 1'b0; fifo_empty = 1'b0;
        fifo_full = 1'b0; parity_done = 1'b0; low_pkt_valid = 1'b0;
        //     rst pv em fu pd lp
        drive(0, 0, 0, 0, 0, 0, S_DEC,  "R2 reset");
        drive(0, 1, 1, 1, 0, 0, S_DEC,  "R2 reset holds");
        drive(1, 0, 1, 0, 0, 0, S_DEC,  "R3 idle without valid");
        drive(1, 1, 0, 0, 0, 0, S_WAIT, "R3 queue not empty");
        drive(1, 1, 0, 0, 0, 0, S_WAIT, "R4 wait holds");
        drive(1, 1, 1, 0, 0, 0, S_FRST, "R4 drained");
        drive(1, 0, 0, 1, 1, 1, S_DATA, "R5 flags ignored");
        drive(1, 1, 0, 0, 0, 0, S_DATA, "R6 stream");
        drive(1, 1, 0, 1, 0, 0, S_FULL, "R6 full during data");
        drive(1, 1, 0, 1, 0, 0, S_FULL, "R8 full holds");
        drive(1, 1, 0, 0, 0, 0, S_LAF,  "R8 full clears");
        drive(1, 1, 0, 0, 0, 0, S_DATA, "R9 resume data");
        drive(1, 0, 0, 0, 0, 0, S_PAR,  "R6 end of payload");
        drive(1, 0, 0, 1, 0, 0, S_FULL, "R7 full during parity");
        drive(1, 0, 0, 0, 0, 1, S_LAF,  "R8 recover");
        drive(1, 0, 0, 0, 0, 1, S_PAR,  "R9 low valid to parity");
        drive(1, 0, 0, 0, 0, 0, S_CHK,  "R7 parity to check");
        drive(1, 0, 0, 1, 0, 0, S_FULL, "R10 full during check");
        drive(1, 0, 0, 0, 1, 1, S_LAF,  "R8 recover again");
        drive(1, 0, 0, 0, 1, 1, S_DEC,  "R9 parity done wins");
        drive(1, 1, 1, 0, 0, 0, S_FRST, "R3 direct to first");
        drive(1, 1, 1, 0, 0, 0, S_DATA, "R5 first to data");
        drive(1, 0, 1, 0, 0, 0, S_PAR,  "R6 short payload");
        drive(1, 0, 1, 0, 0, 0, S_CHK,  "R7 check");
        drive(1, 0, 1, 0, 0, 0, S_DEC,  "R10 back to decode");
        drive(1, 1, 1, 0, 0, 0, S_FRST, "R3 next packet");
        drive(1, 1, 1, 0, 0, 0, S_DATA, "R5 advance");
        drive(0, 1, 1, 0, 0, 0, S_DEC,  "R2 reset mid packet");
        drive(1, 0, 1, 0, 0, 0, S_DEC,  "R1 R3 settled idle");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule